// File: doc/BRIEF.md
# SMBus Target Register Responder

This block sits behind one SMBus target address and turns byte-level bus events into register accesses. A lower layer handles the lines and hands over one event at a time: start, stop, an address byte with its direction bit, a received write byte, a request for a read byte, and the host's acknowledge of a read byte. The block answers address, write and read-request events with a response that carries an acknowledge bit and, for read requests, the byte to drive. All accesses go to an internal 256 x 8 register file.

The first write byte after the address is the command. It selects a register and stays as the current pointer after the transfer ends. Byte, word and process-call accesses need no special decoding. Each transferred byte uses the next register address, so a word lands low byte first. Commands inside a configurable block window make the next write byte a count, limited to 32. That count is stored at the command register and the data follows it. A block read therefore returns the count first and then the data. An address phase followed directly by stop is a quick command, and the block reports its direction bit.

Both event streams use valid/ready. An event is taken on a clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` is low while a response is waiting to be taken. A response is taken on an edge where `rsp_valid` and `rsp_ready` are both high. It stays unchanged until then, so the lower layer can stall the block for as long as it needs.

Top module: `smbt_responder`

## Requirements
- R1: An address event (code 2, `ev_byte[7:1]` address, `ev_byte[0]` 1 = read) that follows a start and matches `own_addr` gets `rsp_ack`=1. Any other address event gets `rsp_ack`=0. After a NACKed address, every write byte is NACKed and changes no register or pointer until the next start.
- R2: In a write transfer, the first write byte (code 3) is the command. It is ACKed and sets the pointer. Each later write byte goes to the current address, then the address increments and wraps from 255 to 0.
- R3: The command pointer persists across stop. A read transfer with no command byte starts at the register named by the most recent command.
- R4: After a command byte, a repeated start and a read address, read requests (code 4) return that register and then consecutive registers. A word is returned low byte first.
- R5: A command in the block window (0x80 to 0xBF) makes the next write byte a count. The count is ACKed and stored at the command register, and that many data bytes follow at consecutive addresses. Data bytes beyond the count are NACKed and not written.
- R6: A block count above 32 is NACKed. All following write bytes are NACKed and not written until start or stop.
- R7: A block read of a block command returns the stored count byte first and then the data bytes that follow it.
- R8: A host acknowledge event (code 5) with `ev_byte[0]`=1 ends the read. Later read requests in that transfer are answered with 0xFF and `rsp_ack`=1.
- R9: A matching address followed directly by stop (code 1) raises `quick_stb` for exactly one cycle, with `quick_rw` equal to the received direction bit. A transfer that moves any byte, or one to another address, raises no strobe.
- R10: Responses are produced only for event codes 2, 3 and 4, one per event, in event order. While `rsp_valid` is high and `rsp_ready` is low, `ev_ready` is low and the response stays unchanged.
- R11: After reset, every register reads 0, the pointer is 0, `rsp_valid` is 0 and `quick_stb` is 0. Start is code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Configured 7-bit target address |
| ev_valid | input | 1 | Bus event offered |
| ev_ready | output | 1 | Event can be taken (no response pending) |
| ev_kind | input | 3 | Event code: 0 start, 1 stop, 2 address, 3 write byte, 4 read request, 5 host acknowledge |
| ev_byte | input | 8 | Event payload |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Lower layer takes the response |
| rsp_ack | output | 1 | 1 = ACK the address or write byte |
| rsp_data | output | 8 | Byte to drive for a read request |
| quick_stb | output | 1 | One-cycle pulse on a completed quick command |
| quick_rw | output | 1 | Direction bit of the last quick command |

## Verification
Two things can happen in the same cycle: a new bus event is offered while the previous response is still being held for the lower layer. The bench drops `rsp_ready` one cycle in three for the whole run and also holds it low for several cycles after one address event. This forces events to wait behind unclaimed responses. Every response is compared in order against a queue of expected acknowledge and data values. During the long hold, `ev_ready` must stay low and the pending acknowledge must stay unchanged.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  typedef enum logic [2:0] {
    EV_START = 3'd0,
    EV_STOP  = 3'd1,
    EV_ADDR  = 3'd2,
    EV_WBYTE = 3'd3,
    EV_RDREQ = 3'd4,
    EV_RDACK = 3'd5
  } ev_kind_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_WDATA,
    PH_WCOUNT,
    PH_WBLK,
    PH_READ,
    PH_DRAIN
  } phase_t;

endpackage

// File: rtl/smbt_regfile.sv
module smbt_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/smbt_rsp.sv
module smbt_rsp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ack_in,
  input  logic [DW-1:0] data_in,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic          rsp_ack,
  output logic [DW-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_ack   <= ack_in;
      rsp_data  <= data_in;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/smbt_seq.sv
module smbt_seq
  import smbt_pkg::*;
#(
  parameter int          AW      = 8,
  parameter int          DW      = 8,
  parameter int          MAX_BLK = 32,
  parameter logic [7:0]  BLK_LO  = 8'h80,
  parameter logic [7:0]  BLK_HI  = 8'hBF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] own_addr,
  input  logic          ev_fire,
  input  logic [2:0]    ev_code,
  input  logic [DW-1:0] ev_byte,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  output logic          rsp_load,
  output logic          rsp_ack,
  output logic [DW-1:0] rsp_byte,
  output logic          quick_stb,
  output logic          quick_rw
);
  localparam int CW = $clog2(MAX_BLK + 1);

  phase_t        phase_q, phase_d;
  logic [AW-1:0] cmd_q, cmd_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [CW-1:0] left_q, left_d;
  logic          qpend_q, qpend_d;
  logic          rw_q, rw_d;
  logic          qstb_d;

  ev_kind_t kind;
  logic     addr_hit;
  logic     in_blk;
  logic     cnt_ok;

  assign kind     = ev_kind_t'(ev_code);
  assign addr_hit = (ev_byte[DW-1:1] == own_addr);
  assign in_blk   = (ev_byte[7:0] >= BLK_LO) && (ev_byte[7:0] <= BLK_HI);
  assign cnt_ok   = (ev_byte <= DW'(MAX_BLK));

  assign wr_addr = cur_q;
  assign wr_data = ev_byte;
  assign rd_addr = cur_q;

  always_comb begin
    phase_d  = phase_q;
    cmd_d    = cmd_q;
    cur_d    = cur_q;
    left_d   = left_q;
    qpend_d  = qpend_q;
    rw_d     = rw_q;
    qstb_d   = 1'b0;
    wr_en    = 1'b0;
    rsp_load = 1'b0;
    rsp_ack  = 1'b0;
    rsp_byte = '1;
    if (ev_fire) begin
      case (kind)
        EV_START: begin
          phase_d = PH_ADDR;
          qpend_d = 1'b0;
        end
        EV_STOP: begin
          phase_d = PH_IDLE;
          qpend_d = 1'b0;
          qstb_d  = qpend_q;
        end
        EV_ADDR: begin
          rsp_load = 1'b1;
          qpend_d  = 1'b0;
          if (phase_q == PH_ADDR && addr_hit) begin
            rsp_ack = 1'b1;
            qpend_d = 1'b1;
            rw_d    = ev_byte[0];
            cur_d   = cmd_q;
            phase_d = ev_byte[0] ? PH_READ : PH_CMD;
          end else begin
            phase_d = PH_DRAIN;
          end
        end
        EV_WBYTE: begin
          rsp_load = 1'b1;
          qpend_d  = 1'b0;
          case (phase_q)
            PH_CMD: begin
              rsp_ack = 1'b1;
              cmd_d   = ev_byte[AW-1:0];
              cur_d   = ev_byte[AW-1:0];
              phase_d = in_blk ? PH_WCOUNT : PH_WDATA;
            end
            PH_WDATA: begin
              rsp_ack = 1'b1;
              wr_en   = 1'b1;
              cur_d   = cur_q + 1'b1;
            end
            PH_WCOUNT: begin
              if (cnt_ok) begin
                rsp_ack = 1'b1;
                wr_en   = 1'b1;
                cur_d   = cur_q + 1'b1;
                left_d  = ev_byte[CW-1:0];
                phase_d = PH_WBLK;
              end else begin
                phase_d = PH_DRAIN;
              end
            end
            PH_WBLK: begin
              if (left_q != '0) begin
                rsp_ack = 1'b1;
                wr_en   = 1'b1;
                cur_d   = cur_q + 1'b1;
                left_d  = left_q - 1'b1;
              end else begin
                phase_d = PH_DRAIN;
              end
            end
            default: phase_d = PH_DRAIN;
          endcase
        end
        EV_RDREQ: begin
          rsp_load = 1'b1;
          rsp_ack  = 1'b1;
          qpend_d  = 1'b0;
          if (phase_q == PH_READ) begin
            rsp_byte = rd_data;
            cur_d    = cur_q + 1'b1;
          end
        end
        EV_RDACK: begin
          if (phase_q == PH_READ && ev_byte[0]) phase_d = PH_DRAIN;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cmd_q     <= '0;
      cur_q     <= '0;
      left_q    <= '0;
      qpend_q   <= 1'b0;
      rw_q      <= 1'b0;
      quick_stb <= 1'b0;
      quick_rw  <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      cmd_q     <= cmd_d;
      cur_q     <= cur_d;
      left_q    <= left_d;
      qpend_q   <= qpend_d;
      rw_q      <= rw_d;
      quick_stb <= qstb_d;
      if (qstb_d) quick_rw <= rw_q;
    end
  end
endmodule

// File: rtl/smbt_responder.sv
module smbt_responder #(
  parameter int          AW      = 8,
  parameter int          DW      = 8,
  parameter int          MAX_BLK = 32,
  parameter logic [7:0]  BLK_LO  = 8'h80,
  parameter logic [7:0]  BLK_HI  = 8'hBF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] own_addr,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [2:0]    ev_kind,
  input  logic [DW-1:0] ev_byte,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_ack,
  output logic [DW-1:0] rsp_data,
  output logic          quick_stb,
  output logic          quick_rw
);
  logic          ev_fire;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          ld;
  logic          ld_ack;
  logic [DW-1:0] ld_byte;

  assign ev_ready = !rsp_valid;
  assign ev_fire  = ev_valid && ev_ready;

  smbt_seq #(
    .AW(AW), .DW(DW), .MAX_BLK(MAX_BLK), .BLK_LO(BLK_LO), .BLK_HI(BLK_HI)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_addr (own_addr),
    .ev_fire  (ev_fire),
    .ev_code  (ev_kind),
    .ev_byte  (ev_byte),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rsp_load (ld),
    .rsp_ack  (ld_ack),
    .rsp_byte (ld_byte),
    .quick_stb(quick_stb),
    .quick_rw (quick_rw)
  );

  smbt_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  smbt_rsp #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld),
    .ack_in    (ld_ack),
    .data_in   (ld_byte),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_ack   (rsp_ack),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/smbt_chk.sv
module smbt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] own_addr,
  input logic       ev_valid,
  input logic       ev_ready,
  input logic [2:0] ev_kind,
  input logic [7:0] ev_byte,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       rsp_ack,
  input logic [7:0] rsp_data,
  input logic       quick_stb
);
  logic fire;
  assign fire = ev_valid && ev_ready;

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ack) && $stable(rsp_data));

  // R10
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(fire && (ev_kind == 3'd2 || ev_kind == 3'd3 || ev_kind == 3'd4)));

  // R1
  foreign_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ev_kind == 3'd2 && ev_byte[7:1] != own_addr |=> rsp_valid && !rsp_ack);

  // R8
  rdreq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ev_kind == 3'd4 |=> rsp_valid && rsp_ack);

  // R9
  quick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quick_stb |=> !quick_stb);

  // R9
  quick_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quick_stb |-> $past(fire && ev_kind == 3'd1));
endmodule

bind smbt_responder smbt_chk u_chk (.*);

// File: tb/tb_smbt_responder.sv
`timescale 1ns/1ps
module tb_smbt_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] own_addr = 7'h2A;
  logic       ev_valid = 1'b0;
  logic       ev_ready;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'd0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic       rsp_ack;
  logic [7:0] rsp_data;
  logic       quick_stb;
  logic       quick_rw;

  always #2 clk = ~clk;

  smbt_responder dut (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
    .quick_stb(quick_stb), .quick_rw(quick_rw)
  );

  int checks = 0, errors = 0;
  int qcount = 0;
  logic qlast = 1'b0;
  int rcnt = 0;
  bit hold = 1'b0;
  logic       ea_q[$];
  logic [7:0] ed_q[$];
  bit         er_q[$];
  string      tag_q[$];

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic send(logic [2:0] k, logic [7:0] b);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic expect_rsp(logic a, logic [7:0] d, bit isrd, string tag);
    ea_q.push_back(a); ed_q.push_back(d); er_q.push_back(isrd); tag_q.push_back(tag);
  endtask

  task automatic t_start(); send(3'd0, 8'h00); endtask
  task automatic t_stop();  send(3'd1, 8'h00); endtask
  task automatic t_addr(logic [6:0] a, logic rw, logic ack, string tag);
    expect_rsp(ack, 8'h00, 1'b0, tag); send(3'd2, {a, rw});
  endtask
  task automatic t_wb(logic [7:0] b, logic ack, string tag);
    expect_rsp(ack, 8'h00, 1'b0, tag); send(3'd3, b);
  endtask
  task automatic t_rd(logic [7:0] d, string tag);
    expect_rsp(1'b1, d, 1'b1, tag); send(3'd4, 8'h00);
  endtask
  task automatic t_hack(logic nack); send(3'd5, {7'd0, nack}); endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic quick_expect(int n, logic rw, bit chk_rw, string tag);
    repeat (3) @(negedge clk);
    chk(qcount == n, tag, "quick strobe count", qcount, n);
    if (chk_rw) chk(qlast == rw, tag, "quick direction", qlast, rw);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    rcnt++;
    rsp_ready = !hold && (rcnt % 3 != 0);
    if (quick_stb) begin qcount++; qlast = quick_rw; end
    if (rst_n && rsp_valid && rsp_ready) begin
      if (ea_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected response", 1, 0);
      end else begin
        logic a; logic [7:0] d; bit r; string t;
        a = ea_q.pop_front(); d = ed_q.pop_front(); r = er_q.pop_front(); t = tag_q.pop_front();
        chk(rsp_ack == a, t, "ack", rsp_ack, a);
        if (r) chk(rsp_data == d, t, "read data", rsp_data, d);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", rsp_valid, 0);
    chk(ev_ready == 1'b1, "R11", "ev_ready after reset", ev_ready, 1);
    chk(quick_stb == 1'b0, "R11", "quick_stb after reset", quick_stb, 0);

    // R11 pointer 0, register 0
    t_start(); t_addr(7'h2A, 1'b1, 1'b1, "R11");
    t_rd(8'h00, "R11"); t_hack(1'b1); t_stop();
    quick_expect(0, 1'b0, 1'b0, "R9");

    // R2 write byte data
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R1");
    t_wb(8'h10, 1'b1, "R2"); t_wb(8'h5A, 1'b1, "R2"); t_stop();
    // R3 read byte without command
    t_start(); t_addr(7'h2A, 1'b1, 1'b1, "R3");
    t_rd(8'h5A, "R3"); t_hack(1'b1); t_stop();

    // R4 word write then word read with repeated start, then R8
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R4");
    t_wb(8'h20, 1'b1, "R4"); t_wb(8'h34, 1'b1, "R4"); t_wb(8'h12, 1'b1, "R4"); t_stop();
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R4"); t_wb(8'h20, 1'b1, "R4");
    t_start(); t_addr(7'h2A, 1'b1, 1'b1, "R4");
    t_rd(8'h34, "R4"); t_hack(1'b0); t_rd(8'h12, "R4"); t_hack(1'b1);
    t_rd(8'hFF, "R8"); t_stop();

    // R2 wrap from 255 to 0
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R2");
    t_wb(8'hFF, 1'b1, "R2"); t_wb(8'hA1, 1'b1, "R2"); t_wb(8'hB2, 1'b1, "R2"); t_stop();
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R2"); t_wb(8'hFF, 1'b1, "R2");
    t_start(); t_addr(7'h2A, 1'b1, 1'b1, "R2");
    t_rd(8'hA1, "R2"); t_hack(1'b0); t_rd(8'hB2, "R2"); t_hack(1'b1); t_stop();

    // R5 block write with extra byte, R7 block read
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R5"); t_wb(8'h90, 1'b1, "R5");
    t_wb(8'h03, 1'b1, "R5"); t_wb(8'h01, 1'b1, "R5"); t_wb(8'h02, 1'b1, "R5");
    t_wb(8'h03, 1'b1, "R5"); t_wb(8'h04, 1'b0, "R5"); t_stop();
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R7"); t_wb(8'h90, 1'b1, "R7");
    t_start(); t_addr(7'h2A, 1'b1, 1'b1, "R7");
    t_rd(8'h03, "R7"); t_hack(1'b0); t_rd(8'h01, "R7"); t_hack(1'b0);
    t_rd(8'h02, "R7"); t_hack(1'b0); t_rd(8'h03, "R7"); t_hack(1'b0);
    t_rd(8'h00, "R5"); t_hack(1'b1); t_stop();

    // R6 count of 33 refused
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R6"); t_wb(8'hA0, 1'b1, "R6");
    t_wb(8'h21, 1'b0, "R6"); t_wb(8'h77, 1'b0, "R6"); t_stop();
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R6"); t_wb(8'hA0, 1'b1, "R6");
    t_start(); t_addr(7'h2A, 1'b1, 1'b1, "R6");
    t_rd(8'h00, "R6"); t_hack(1'b0); t_rd(8'h00, "R6"); t_hack(1'b1); t_stop();

    // R5 boundary count of 32
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R5"); t_wb(8'hB0, 1'b1, "R5");
    t_wb(8'h20, 1'b1, "R5");
    for (int i = 0; i < 32; i++) t_wb(8'(i + 1), 1'b1, "R5");
    t_wb(8'h99, 1'b0, "R5"); t_stop();
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R7"); t_wb(8'hB0, 1'b1, "R7");
    t_start(); t_addr(7'h2A, 1'b1, 1'b1, "R7");
    t_rd(8'h20, "R7"); t_hack(1'b0); t_rd(8'h01, "R7"); t_hack(1'b1); t_stop();

    // R1 foreign address ignored, pointer untouched
    t_start(); t_addr(7'h2B, 1'b0, 1'b0, "R1");
    t_wb(8'h10, 1'b0, "R1"); t_wb(8'hEE, 1'b0, "R1"); t_stop();
    t_start(); t_addr(7'h2A, 1'b1, 1'b1, "R1");
    t_rd(8'h20, "R1"); t_hack(1'b1); t_stop();
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R1"); t_wb(8'h10, 1'b1, "R1");
    t_start(); t_addr(7'h2A, 1'b1, 1'b1, "R1");
    t_rd(8'h5A, "R1"); t_hack(1'b1); t_stop();

    // R9 quick commands
    t_start(); t_addr(7'h2A, 1'b0, 1'b1, "R9"); t_stop();
    quick_expect(1, 1'b0, 1'b1, "R9");
    t_start(); t_addr(7'h2A, 1'b1, 1'b1, "R9"); t_stop();
    quick_expect(2, 1'b1, 1'b1, "R9");
    t_start(); t_addr(7'h33, 1'b1, 1'b0, "R9"); t_stop();
    quick_expect(2, 1'b1, 1'b0, "R9");

    // R10 back-pressure hold
    t_start();
    hold = 1'b1;
    t_addr(7'h2A, 1'b0, 1'b1, "R10");
    repeat (4) @(negedge clk);
    chk(rsp_valid == 1'b1, "R10", "response held", rsp_valid, 1);
    chk(ev_ready == 1'b0, "R10", "ev_ready during hold", ev_ready, 0);
    chk(rsp_ack == 1'b1, "R10", "held ack", rsp_ack, 1);
    hold = 1'b0;
    t_stop();
    quick_expect(3, 1'b0, 1'b1, "R9");

    settle();
    chk(ea_q.size() == 0, "R10", "responses outstanding", ea_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule